// File: doc/BRIEF.md
# Dual-Stack Processor Execute Unit

This block is the execute stage of a 32-bit zero-operand processor that keeps its operands in a data stack and a return stack. Each issued 5-bit opcode comes with the current top of data stack (T), the element beneath it (S), the top of return stack (R) and the A and P address registers. The unit returns the new top of stack, push/pop commands for the two stack arrays, new R, A and P values with write enables, and drives a memory port. The stack arrays, the instruction fetch logic and the control-transfer opcodes belong to neighbouring blocks. Opcodes 00 to 07 pass through with no effect here.

The arithmetic and stack-shuffling opcodes occupy 10 to 1f and never touch memory. Opcodes 08 to 0f move one word between memory and the stack, addressed only through P, A or the write-only B register. B lives inside this unit and has no read path other than its use as an address. Any address with bit 31 set selects the port space. Auto-increment is suppressed there so that repeated accesses keep hitting the same port.

The memory port is combinational: the address and strobes follow the issued opcode in the same cycle, and read data is expected back in that cycle. All other results are registered and appear one cycle after issue together with `res_valid`.

Top module: `stk_exec_unit`

## Requirements
- R1: While reset is applied and after its release, until the first issue, `res_valid`, `a_we`, `p_we`, `mem_rd` and `mem_wr` are 0, `ds_cmd` and `rs_cmd` are hold (2'b00), and `t_out` is 0. B starts at 32'h8000_0000, which is the address driven by the first B-addressed access.
- R2: Results appear on the cycle after `op_valid` is high, with `res_valid` high for exactly that cycle. In a cycle with no issue, `res_valid` is 0 and `t_out` keeps its value. Stack command encoding: 2'b00 hold, 2'b01 push, 2'b10 pop.
- R3: Opcodes 14, 15 and 16 set T to T+S (modulo 2^32), T and S, and T xor S respectively, and pop the data stack. No opcode from 10 to 1f raises a memory strobe.
- R4: Opcode 11 shifts T left by one bit, opcode 12 shifts it right by one bit while keeping bit 31, and opcode 13 inverts every bit. The data stack holds.
- R5: Opcode 17 gives T=S and a pop; 18 gives T unchanged and a push; 1a gives T=S and a push; 1c changes nothing. Opcode 19 gives T=R, a data push and a return pop. Opcode 1d gives R=T, T=S, a data pop and a return push.
- R6: Opcode 1b gives T=A and a push. Opcode 1f loads A from T (`a_we`=1), and opcode 1e loads B from T. Both give T=S and a pop.
- R7: Opcodes 08, 09, 0b and 0a raise `mem_rd` in the issue cycle with address P, A, A and B respectively. They set T to the read data and push.
- R8: Opcodes 0c, 0d, 0f and 0e raise `mem_wr` in the issue cycle with address P, A, A and B and write data T. They set T=S and pop. Read and write are never raised together.
- R9: Opcodes 08 and 0c return P+1 with `p_we`=1, and 09 and 0d return A+1 with `a_we`=1, when the address has bit 31 clear. Opcodes 0a, 0b, 0e and 0f change neither register.
- R10: When the address used by 08, 0c, 09 or 0d has bit 31 set, the register is not incremented and its write enable stays 0.
- R11: Opcode 10 adds S to T when A bit 0 is 1, then shifts the 65-bit {carry, T, A} right by one and returns the new T and A with `a_we`=1. Thirty-two steps from T=0 give the unsigned product of A and S in {T, A}.
- R12: Opcodes 00 to 07 give T, R, A and P unchanged, both stacks hold, and no strobe or write enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | An opcode is issued this cycle |
| op_code | input | 5 | Opcode |
| t_in | input | 32 | Top of data stack |
| s_in | input | 32 | Second data stack element |
| r_in | input | 32 | Top of return stack |
| a_in | input | 32 | A register |
| p_in | input | 32 | P register |
| mem_rdata | input | 32 | Read data, returned in the issue cycle |
| mem_addr | output | 32 | Memory or port address |
| mem_wdata | output | 32 | Write data |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| res_valid | output | 1 | Registered results are valid |
| t_out | output | 32 | New top of data stack |
| ds_cmd | output | 2 | Data stack command |
| r_out | output | 32 | New top of return stack |
| rs_cmd | output | 2 | Return stack command |
| a_out | output | 32 | New A value |
| a_we | output | 1 | A write enable |
| p_out | output | 32 | New P value |
| p_we | output | 1 | P write enable |

## Verification
The bench sweeps all 32 opcodes over eight operand sets that include all-zero, all-one and sign-bit-only values, A and P on both sides of the port boundary, and A at 32'h7FFF_FFFF. A logical right shift would lose bit 31 on the negative cases, and a two's-complement negate in place of the invert would be off by one. A xor implemented as inclusive or would differ whenever both operands share a set bit. An increment not gated by bit 31 would step a port address, and an incorrect B path would misaddress the B-based accesses after reset and after each B load. Chained multiply steps over three operand pairs catch a lost carry or a wrong shift order, because either one corrupts the 64-bit product.

// File: rtl/stk_exec_pkg.sv
package stk_exec_pkg;

  localparam int OPC_W = 5;
  typedef logic [OPC_W-1:0] opc_t;

  localparam opc_t OP_FETCH_P  = 5'h08;
  localparam opc_t OP_FETCH_AI = 5'h09;
  localparam opc_t OP_FETCH_B  = 5'h0a;
  localparam opc_t OP_FETCH_A  = 5'h0b;
  localparam opc_t OP_STORE_P  = 5'h0c;
  localparam opc_t OP_STORE_AI = 5'h0d;
  localparam opc_t OP_STORE_B  = 5'h0e;
  localparam opc_t OP_STORE_A  = 5'h0f;
  localparam opc_t OP_MULSTEP  = 5'h10;
  localparam opc_t OP_SHL      = 5'h11;
  localparam opc_t OP_SHR      = 5'h12;
  localparam opc_t OP_INV      = 5'h13;
  localparam opc_t OP_ADD      = 5'h14;
  localparam opc_t OP_AND      = 5'h15;
  localparam opc_t OP_XOR      = 5'h16;
  localparam opc_t OP_DROP     = 5'h17;
  localparam opc_t OP_DUP      = 5'h18;
  localparam opc_t OP_RPOP     = 5'h19;
  localparam opc_t OP_OVER     = 5'h1a;
  localparam opc_t OP_GETA     = 5'h1b;
  localparam opc_t OP_NOP      = 5'h1c;
  localparam opc_t OP_RPUSH    = 5'h1d;
  localparam opc_t OP_SETB     = 5'h1e;
  localparam opc_t OP_SETA     = 5'h1f;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_cmd_e;

  typedef enum logic [1:0] {
    ASRC_P    = 2'd0,
    ASRC_A    = 2'd1,
    ASRC_B    = 2'd2,
    ASRC_NONE = 2'd3
  } asrc_e;

  typedef enum logic [2:0] {
    TSRC_KEEP = 3'd0,
    TSRC_ALU  = 3'd1,
    TSRC_S    = 3'd2,
    TSRC_R    = 3'd3,
    TSRC_A    = 3'd4,
    TSRC_MEM  = 3'd5
  } tsrc_e;

  typedef struct packed {
    stk_cmd_e ds;
    stk_cmd_e rs;
    logic     rd;
    logic     wr;
    asrc_e    asrc;
    logic     inc_p;
    logic     inc_a;
    tsrc_e    tsrc;
    logic     a_ld;
    logic     b_ld;
    logic     r_ld;
    logic     mul;
  } ctl_t;

endpackage

// File: rtl/stk_exec_decode.sv
module stk_exec_decode
  import stk_exec_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output ctl_t             ctl
);

  always_comb begin
    ctl       = '0;
    ctl.ds    = STK_HOLD;
    ctl.rs    = STK_HOLD;
    ctl.asrc  = ASRC_NONE;
    ctl.tsrc  = TSRC_KEEP;
    case (op)
      OP_FETCH_P:  begin ctl.ds = STK_PUSH; ctl.rd = 1'b1; ctl.asrc = ASRC_P; ctl.inc_p = 1'b1; ctl.tsrc = TSRC_MEM; end
      OP_FETCH_AI: begin ctl.ds = STK_PUSH; ctl.rd = 1'b1; ctl.asrc = ASRC_A; ctl.inc_a = 1'b1; ctl.tsrc = TSRC_MEM; end
      OP_FETCH_B:  begin ctl.ds = STK_PUSH; ctl.rd = 1'b1; ctl.asrc = ASRC_B; ctl.tsrc = TSRC_MEM; end
      OP_FETCH_A:  begin ctl.ds = STK_PUSH; ctl.rd = 1'b1; ctl.asrc = ASRC_A; ctl.tsrc = TSRC_MEM; end
      OP_STORE_P:  begin ctl.ds = STK_POP;  ctl.wr = 1'b1; ctl.asrc = ASRC_P; ctl.inc_p = 1'b1; ctl.tsrc = TSRC_S; end
      OP_STORE_AI: begin ctl.ds = STK_POP;  ctl.wr = 1'b1; ctl.asrc = ASRC_A; ctl.inc_a = 1'b1; ctl.tsrc = TSRC_S; end
      OP_STORE_B:  begin ctl.ds = STK_POP;  ctl.wr = 1'b1; ctl.asrc = ASRC_B; ctl.tsrc = TSRC_S; end
      OP_STORE_A:  begin ctl.ds = STK_POP;  ctl.wr = 1'b1; ctl.asrc = ASRC_A; ctl.tsrc = TSRC_S; end
      OP_MULSTEP:  begin ctl.tsrc = TSRC_ALU; ctl.mul = 1'b1; end
      OP_SHL, OP_SHR, OP_INV: ctl.tsrc = TSRC_ALU;
      OP_ADD, OP_AND, OP_XOR: begin ctl.ds = STK_POP; ctl.tsrc = TSRC_ALU; end
      OP_DROP:     begin ctl.ds = STK_POP;  ctl.tsrc = TSRC_S; end
      OP_DUP:      ctl.ds = STK_PUSH;
      OP_RPOP:     begin ctl.ds = STK_PUSH; ctl.rs = STK_POP; ctl.tsrc = TSRC_R; end
      OP_OVER:     begin ctl.ds = STK_PUSH; ctl.tsrc = TSRC_S; end
      OP_GETA:     begin ctl.ds = STK_PUSH; ctl.tsrc = TSRC_A; end
      OP_NOP:      ctl.tsrc = TSRC_KEEP;
      OP_RPUSH:    begin ctl.ds = STK_POP;  ctl.rs = STK_PUSH; ctl.tsrc = TSRC_S; ctl.r_ld = 1'b1; end
      OP_SETB:     begin ctl.ds = STK_POP;  ctl.tsrc = TSRC_S; ctl.b_ld = 1'b1; end
      OP_SETA:     begin ctl.ds = STK_POP;  ctl.tsrc = TSRC_S; ctl.a_ld = 1'b1; end
      default:     ctl.tsrc = TSRC_KEEP;
    endcase
  end

endmodule

// File: rtl/stk_exec_alu.sv
module stk_exec_alu
  import stk_exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [OPC_W-1:0] op,
  input  logic [DW-1:0]    t,
  input  logic [DW-1:0]    s,
  input  logic [DW-1:0]    a,
  output logic [DW-1:0]    res,
  output logic [DW-1:0]    a_mul
);

  logic [DW:0] mstep_sum;

  // Multiply step: conditional add into a carry-extended T, then the
  // carry, T and A shift right together by one bit.
  always_comb begin
    mstep_sum = {1'b0, t} + (a[0] ? {1'b0, s} : {(DW+1){1'b0}});
    a_mul     = {mstep_sum[0], a[DW-1:1]};
  end

  always_comb begin
    case (op)
      OP_MULSTEP: res = mstep_sum[DW:1];
      OP_SHL:     res = {t[DW-2:0], 1'b0};
      OP_SHR:     res = {t[DW-1], t[DW-1:1]};
      OP_INV:     res = ~t;
      OP_ADD:     res = t + s;
      OP_AND:     res = t & s;
      OP_XOR:     res = t ^ s;
      default:    res = t;
    endcase
  end

endmodule

// File: rtl/stk_exec_mem.sv
module stk_exec_mem
  import stk_exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          issue,
  input  logic          rd_req,
  input  logic          wr_req,
  input  asrc_e         asrc,
  input  logic          inc_p,
  input  logic          inc_a,
  input  logic [DW-1:0] p,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] t,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          rd,
  output logic          wr,
  output logic          p_step_we,
  output logic [DW-1:0] p_step,
  output logic          a_step_we,
  output logic [DW-1:0] a_step
);

  localparam int PORT_BIT = DW - 1;

  always_comb begin
    case (asrc)
      ASRC_P:  addr = p;
      ASRC_A:  addr = a;
      ASRC_B:  addr = b;
      default: addr = '0;
    endcase
  end

  assign wdata = t;
  assign rd    = issue & rd_req;
  assign wr    = issue & wr_req;

  // Post-increment only while the register points into RAM.
  assign p_step_we = inc_p & ~p[PORT_BIT];
  assign p_step    = p + DW'(1);
  assign a_step_we = inc_a & ~a[PORT_BIT];
  assign a_step    = a + DW'(1);

endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_exec_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic [DW-1:0] t_in,
  input  logic [DW-1:0] s_in,
  input  logic [DW-1:0] r_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] p_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          res_valid,
  output logic [DW-1:0] t_out,
  output logic [1:0]    ds_cmd,
  output logic [DW-1:0] r_out,
  output logic [1:0]    rs_cmd,
  output logic [DW-1:0] a_out,
  output logic          a_we,
  output logic [DW-1:0] p_out,
  output logic          p_we
);

  localparam logic [DW-1:0] B_RST = {1'b1, {(DW-1){1'b0}}};

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  logic issue;
  assign issue = op_valid & rst_ok;

  ctl_t          ctl;
  logic [DW-1:0] alu_res, a_mul;
  logic [DW-1:0] b_q;
  logic          p_step_we, a_step_we;
  logic [DW-1:0] p_step, a_step;

  stk_exec_decode u_dec (
    .op  (op_code),
    .ctl (ctl)
  );

  stk_exec_alu #(.DW(DW)) u_alu (
    .op    (op_code),
    .t     (t_in),
    .s     (s_in),
    .a     (a_in),
    .res   (alu_res),
    .a_mul (a_mul)
  );

  stk_exec_mem #(.DW(DW)) u_mem (
    .issue     (issue),
    .rd_req    (ctl.rd),
    .wr_req    (ctl.wr),
    .asrc      (ctl.asrc),
    .inc_p     (ctl.inc_p),
    .inc_a     (ctl.inc_a),
    .p         (p_in),
    .a         (a_in),
    .b         (b_q),
    .t         (t_in),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .rd        (mem_rd),
    .wr        (mem_wr),
    .p_step_we (p_step_we),
    .p_step    (p_step),
    .a_step_we (a_step_we),
    .a_step    (a_step)
  );

  // Next-state selection
  logic [DW-1:0] t_nxt, r_nxt, a_nxt, p_nxt;
  logic          a_we_nxt, p_we_nxt;

  always_comb begin
    case (ctl.tsrc)
      TSRC_ALU: t_nxt = alu_res;
      TSRC_S:   t_nxt = s_in;
      TSRC_R:   t_nxt = r_in;
      TSRC_A:   t_nxt = a_in;
      TSRC_MEM: t_nxt = mem_rdata;
      default:  t_nxt = t_in;
    endcase

    r_nxt = ctl.r_ld ? t_in : r_in;

    if (ctl.mul) begin
      a_nxt = a_mul;  a_we_nxt = 1'b1;
    end else if (ctl.a_ld) begin
      a_nxt = t_in;   a_we_nxt = 1'b1;
    end else if (a_step_we) begin
      a_nxt = a_step; a_we_nxt = 1'b1;
    end else begin
      a_nxt = a_in;   a_we_nxt = 1'b0;
    end

    p_we_nxt = p_step_we;
    p_nxt    = p_step_we ? p_step : p_in;
  end

  // Result registers: command pulses every cycle, data under issue enable.
  logic          vld_q, a_we_q, p_we_q;
  stk_cmd_e      ds_q, rs_q;
  logic [DW-1:0] t_q, r_q, a_q, p_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      vld_q  <= 1'b0;
      ds_q   <= STK_HOLD;
      rs_q   <= STK_HOLD;
      a_we_q <= 1'b0;
      p_we_q <= 1'b0;
      t_q    <= '0;
      r_q    <= '0;
      a_q    <= '0;
      p_q    <= '0;
      b_q    <= B_RST;
    end else begin
      vld_q  <= issue;
      ds_q   <= issue ? ctl.ds : STK_HOLD;
      rs_q   <= issue ? ctl.rs : STK_HOLD;
      a_we_q <= issue & a_we_nxt;
      p_we_q <= issue & p_we_nxt;
      if (issue) begin
        t_q <= t_nxt;
        r_q <= r_nxt;
        a_q <= a_nxt;
        p_q <= p_nxt;
      end
      if (issue && ctl.b_ld) begin
        b_q <= t_in;
      end
    end
  end

  assign res_valid = vld_q;
  assign t_out     = t_q;
  assign ds_cmd    = ds_q;
  assign r_out     = r_q;
  assign rs_cmd    = rs_q;
  assign a_out     = a_q;
  assign a_we      = a_we_q;
  assign p_out     = p_q;
  assign p_we      = p_we_q;

endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_ok,
  input logic          op_valid,
  input logic [4:0]    op_code,
  input logic [DW-1:0] t_in,
  input logic [DW-1:0] s_in,
  input logic [DW-1:0] a_in,
  input logic [DW-1:0] p_in,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          res_valid,
  input logic [DW-1:0] t_out,
  input logic [1:0]    ds_cmd,
  input logic          a_we,
  input logic          p_we
);

  p_issue_lat_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> res_valid);

  p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> !res_valid);

  p_alu_nomem_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code[4]) |-> (!mem_rd && !mem_wr));

  p_xor_pop_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && op_code == 5'h16) |=> (t_out == $past(t_in ^ s_in) && ds_cmd == 2'b10));

  p_rdwr_excl_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    !(mem_rd && mem_wr));

  p_port_p_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && (op_code == 5'h08 || op_code == 5'h0c) && p_in[DW-1]) |=> !p_we);

  p_port_a_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && (op_code == 5'h09 || op_code == 5'h0d) && a_in[DW-1]) |=> !a_we);

  p_xfer_quiet_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && !op_code[4] && !op_code[3]) |=> (ds_cmd == 2'b00 && !a_we && !p_we));

endmodule

bind stk_exec_unit stk_exec_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .t_in      (t_in),
  .s_in      (s_in),
  .a_in      (a_in),
  .p_in      (p_in),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .res_valid (res_valid),
  .t_out     (t_out),
  .ds_cmd    (ds_cmd),
  .a_we      (a_we),
  .p_we      (p_we)
);

// File: tb/stk_exec_unit_tb_top.sv
module stk_exec_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_code;
  logic [31:0] t_in, s_in, r_in, a_in, p_in, mem_rdata;
  logic [31:0] mem_addr, mem_wdata, t_out, r_out, a_out, p_out;
  logic        mem_rd, mem_wr, res_valid, a_we, p_we;
  logic [1:0]  ds_cmd, rs_cmd;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] b_model;

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [31:0] ad);
    return (ad * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  always_comb mem_rdata = mem_model(mem_addr);

  stk_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .t_in(t_in), .s_in(s_in), .r_in(r_in), .a_in(a_in), .p_in(p_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .res_valid(res_valid), .t_out(t_out),
    .ds_cmd(ds_cmd), .r_out(r_out), .rs_cmd(rs_cmd), .a_out(a_out),
    .a_we(a_we), .p_out(p_out), .p_we(p_we)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] op);
    if (op < 5'h08) return "R12";
    if (op < 5'h0c) return "R7";
    if (op < 5'h10) return "R8";
    if (op == 5'h10) return "R11";
    if (op < 5'h14) return "R4";
    if (op < 5'h17) return "R3";
    if (op == 5'h1b || op == 5'h1e || op == 5'h1f) return "R6";
    return "R5";
  endfunction

  // Expected values, written from the requirements
  logic [31:0] e_t, e_r, e_a, e_p, e_addr;
  logic [1:0]  e_ds, e_rs;
  logic        e_awe, e_pwe, e_rd, e_wr, e_inc_op;

  task automatic predict(input logic [4:0] op, input logic [31:0] t, s, r, a, p);
    logic [32:0] sum;
    e_t = t; e_r = r; e_a = a; e_p = p; e_addr = 32'h0;
    e_ds = 2'b00; e_rs = 2'b00; e_awe = 1'b0; e_pwe = 1'b0;
    e_rd = 1'b0; e_wr = 1'b0; e_inc_op = 1'b0;
    case (op)
      5'h08, 5'h0c: begin
        e_addr = p; e_inc_op = 1'b1;
        if (!p[31]) begin e_pwe = 1'b1; e_p = p + 32'd1; end
      end
      5'h09, 5'h0d: begin
        e_addr = a; e_inc_op = 1'b1;
        if (!a[31]) begin e_awe = 1'b1; e_a = a + 32'd1; end
      end
      5'h0b, 5'h0f: e_addr = a;
      5'h0a, 5'h0e: e_addr = b_model;
      default: ;
    endcase
    if (op >= 5'h08 && op <= 5'h0b) begin
      e_rd = 1'b1; e_t = mem_model(e_addr); e_ds = 2'b01;
    end
    if (op >= 5'h0c && op <= 5'h0f) begin
      e_wr = 1'b1; e_t = s; e_ds = 2'b10;
    end
    case (op)
      5'h10: begin
        sum   = {1'b0, t} + (a[0] ? {1'b0, s} : 33'd0);
        e_t   = sum[32:1];
        e_a   = {sum[0], a[31:1]};
        e_awe = 1'b1;
      end
      5'h11: e_t = t << 1;
      5'h12: e_t = {t[31], t[31:1]};
      5'h13: e_t = ~t;
      5'h14: begin e_t = t + s; e_ds = 2'b10; end
      5'h15: begin e_t = t & s; e_ds = 2'b10; end
      5'h16: begin e_t = t ^ s; e_ds = 2'b10; end
      5'h17: begin e_t = s; e_ds = 2'b10; end
      5'h18: e_ds = 2'b01;
      5'h19: begin e_t = r; e_ds = 2'b01; e_rs = 2'b10; end
      5'h1a: begin e_t = s; e_ds = 2'b01; end
      5'h1b: begin e_t = a; e_ds = 2'b01; end
      5'h1d: begin e_r = t; e_t = s; e_ds = 2'b10; e_rs = 2'b01; end
      5'h1e: begin e_t = s; e_ds = 2'b10; end
      5'h1f: begin e_t = s; e_ds = 2'b10; e_a = t; e_awe = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [4:0] op, input logic [31:0] t, s, r, a, p);
    string tg, itg;
    predict(op, t, s, r, a, p);
    tg  = tag_of(op);
    itg = e_inc_op ? (e_addr[31] ? "R10" : "R9") : tg;
    @(negedge clk);
    op_code = op; t_in = t; s_in = s; r_in = r; a_in = a; p_in = p;
    op_valid = 1'b1;
    #2;
    chk(tg, "mem_rd", {31'd0, mem_rd}, {31'd0, e_rd});
    chk((op[4] ? "R3" : tg), "mem_wr", {31'd0, mem_wr}, {31'd0, e_wr});
    if (e_rd || e_wr) chk(tg, "mem_addr", mem_addr, e_addr);
    if (e_wr) chk("R8", "mem_wdata", mem_wdata, t);
    @(negedge clk);
    chk("R2", "res_valid", {31'd0, res_valid}, 32'd1);
    chk(tg, "t_out", t_out, e_t);
    chk(tg, "ds_cmd", {30'd0, ds_cmd}, {30'd0, e_ds});
    chk(tg, "rs_cmd", {30'd0, rs_cmd}, {30'd0, e_rs});
    chk(tg, "r_out", r_out, e_r);
    chk(itg, "a_we", {31'd0, a_we}, {31'd0, e_awe});
    if (e_awe) chk(itg, "a_out", a_out, e_a);
    chk(itg, "p_we", {31'd0, p_we}, {31'd0, e_pwe});
    if (e_pwe) chk(itg, "p_out", p_out, e_p);
    op_valid = 1'b0;
    if (op == 5'h1e) b_model = t;
  endtask

  function automatic logic [31:0] pat_t(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h1234_5678;
      5: return 32'h7FFF_FFFF;
      6: return 32'hDEAD_BEEF;
      default: return 32'h0F0F_F0F0;
    endcase
  endfunction

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] tc, ac, held;
    logic [63:0] prod;
    rst_n = 1'b0; op_valid = 1'b0; op_code = 5'h00;
    t_in = '0; s_in = '0; r_in = '0; a_in = '0; p_in = '0;
    b_model = 32'h8000_0000;
    repeat (4) @(negedge clk);
    chk("R1", "res_valid in reset", {31'd0, res_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: quiet state after release
    chk("R1", "res_valid", {31'd0, res_valid}, 32'd0);
    chk("R1", "ds_cmd", {30'd0, ds_cmd}, 32'd0);
    chk("R1", "rs_cmd", {30'd0, rs_cmd}, 32'd0);
    chk("R1", "a_we", {31'd0, a_we}, 32'd0);
    chk("R1", "p_we", {31'd0, p_we}, 32'd0);
    chk("R1", "mem_rd", {31'd0, mem_rd}, 32'd0);
    chk("R1", "mem_wr", {31'd0, mem_wr}, 32'd0);
    chk("R1", "t_out", t_out, 32'd0);
    // R1: B reset value seen as the address of a B-based fetch
    op_code = 5'h0a; op_valid = 1'b1;
    #2;
    chk("R1", "B reset address", mem_addr, 32'h8000_0000);
    @(negedge clk);
    op_valid = 1'b0;

    // Sweep every opcode over each operand set
    for (int k = 0; k < 8; k++) begin
      for (int op = 0; op < 32; op++) begin
        logic [31:0] t, s, r, a, p;
        t = pat_t(k);
        s = {t[15:0], t[31:16]} ^ 32'hA5A5_3C3C;
        r = t + 32'h1111_0001;
        a = (k == 4) ? 32'h7FFF_FFFF : {k[0], t[30:0]};
        p = (k % 3 == 0) ? (32'h8000_0040 + k) : (32'h0000_0100 + k);
        run_op(op[4:0], t, s, r, a, p);
      end
      // R2: idle cycle leaves res_valid low and t_out held
      held = t_out;
      @(negedge clk);
      chk("R2", "idle res_valid", {31'd0, res_valid}, 32'd0);
      chk("R2", "idle t_out hold", t_out, held);
    end

    // R11: chained multiply steps form the full product
    for (int j = 0; j < 3; j++) begin
      logic [31:0] x, y;
      x = (j == 0) ? 32'hFFFF_FFFF : (j == 1) ? 32'h0001_2345 : 32'h8000_0001;
      y = (j == 0) ? 32'hFFFF_FFFF : (j == 1) ? 32'h0000_0ABC : 32'h7654_3210;
      tc = 32'h0; ac = x;
      for (int i = 0; i < 32; i++) begin
        run_op(5'h10, tc, y, 32'h0, ac, 32'h0);
        tc = t_out; ac = a_out;
      end
      prod = {32'h0, x} * {32'h0, y};
      chk("R11", "product high", tc, prod[63:32]);
      chk("R11", "product low", ac, prod[31:0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule